// File: doc/BRIEF.md
# Packed-Byte Media Execution Unit

This block is a 32-bit execution unit for media kernels. It splits each 32-bit source operand into four byte lanes or two halfword lanes and processes every lane in the same cycle. Each issue runs one of five operations. Three are dot products: byte lanes with both operands signed, byte lanes with a signed first operand and an unsigned second operand, and signed halfword lanes. The fourth is a byte-wise absolute-difference reduction for motion search. The fifth is a quad byte addition that clamps each lane instead of wrapping.

A pipeline feeds two operands, a 3-bit operation code and a valid strobe. The result comes out of a single register stage on the next clock, together with its own valid flag. The last result stays on the output until the next accepted issue.

Top module: `media_simd_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid` is 0 and `res_data` is 0. Reset is asynchronous on assertion and is released on a clock edge.
- R2: `res_valid` is 1 in the cycle after a clock edge that samples `in_valid` high, and 0 in the cycle after an edge that samples it low. The result of an issue appears exactly one clock after the issue.
- R3: Code 0 treats each byte of both operands as a signed two's-complement value. It multiplies the four lane pairs (byte i of A with byte i of B, where byte i is bits 8i+7:8i) and returns the sum as a signed 32-bit value.
- R4: Code 1 works like code 0, except that the bytes of `src_b` are read as unsigned (0..255). The bytes of `src_a` stay signed, and the sum is still a signed 32-bit value.
- R5: Code 2 multiplies the signed low halfwords (bits 15:0) and the signed high halfwords (bits 31:16) of the two operands. It adds the two products and returns the low 32 bits of the sum. When both operands are 0x80008000 the result is 0x80000000.
- R6: Code 3 returns the sum of the four unsigned absolute byte differences |A_i − B_i|, zero-extended to 32 bits. The result never exceeds 1020.
- R7: Code 4 adds each unsigned byte of `src_a` to the signed byte in the same lane of `src_b`. Each lane result is clamped to 0..255, lane i goes to bits 8i+7:8i, and each lane saturates independently of the others.
- R8: Codes 5, 6 and 7 produce a result of 0 with `res_valid` high.
- R9: `res_data` keeps its value across cycles in which `in_valid` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe for the operands and code |
| op_sel | input | 3 | Operation code (0..4 defined) |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| res_valid | output | 1 | Result valid, one clock after issue |
| res_data | output | 32 | Registered result |

## Verification
The byte dot products are driven with all-0x80 lanes and with all-0xFF lanes. Codes 0 and 1 return different sums for these patterns, so a signedness error on either operand shows up. A mixed pattern with distinct lane values catches lane swaps and bad byte ordering. The halfword product is tried at its wrap point and on mixed-sign halves.

The absolute-difference operation is given operands where A is below B in some lanes and above it in others, which exposes a missing absolute value. It is also given its maximum case of 1020. The saturating add uses lanes that overflow, underflow and stay in range in the same word, so a clamp that spreads across lanes or that wraps is caught.

// File: rtl/media_simd_pkg.sv
package media_simd_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    OP_DOT8_SS = 3'd0,
    OP_DOT8_SU = 3'd1,
    OP_DOT16   = 3'd2,
    OP_SAD8    = 3'd3,
    OP_ADDSAT8 = 3'd4
  } media_op_e;
endpackage

// File: rtl/simd_lane_dot.sv
module simd_lane_dot #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              a_signed,
  input  logic              b_signed,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] dot
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int EW    = LANE_W + 1;

  logic signed [DATA_W-1:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [EW-1:0] ext_a;
    logic signed [EW-1:0] ext_b;
    assign ext_a = {a_signed & opa[g*LANE_W+LANE_W-1], opa[g*LANE_W +: LANE_W]};
    assign ext_b = {b_signed & opb[g*LANE_W+LANE_W-1], opb[g*LANE_W +: LANE_W]};
    assign prod[g] = DATA_W'(ext_a) * DATA_W'(ext_b);
  end

  always_comb begin
    logic signed [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + prod[i];
    end
    dot = acc;
  end
endmodule

// File: rtl/simd_lane_sad.sv
module simd_lane_sad #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sad
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int SW    = LANE_W + $clog2(LANES);

  logic [LANE_W-1:0] diff [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la;
    logic [LANE_W-1:0] lb;
    assign la = opa[g*LANE_W +: LANE_W];
    assign lb = opb[g*LANE_W +: LANE_W];
    assign diff[g] = (la >= lb) ? (la - lb) : (lb - la);
  end

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc = acc + SW'(diff[i]);
    end
    sad = DATA_W'(acc);
  end
endmodule

// File: rtl/simd_lane_addsat.sv
module simd_lane_addsat #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sum
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int XW    = LANE_W + 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0]   ua;
    logic [LANE_W-1:0]   sb;
    logic signed [XW-1:0] raw;
    logic [LANE_W-1:0]   clip;
    assign ua  = opa[g*LANE_W +: LANE_W];
    assign sb  = opb[g*LANE_W +: LANE_W];
    assign raw = $signed({2'b00, ua}) + $signed({{2{sb[LANE_W-1]}}, sb});

    always_comb begin
      if (raw[XW-1])      clip = '0;
      else if (raw[XW-2]) clip = '1;
      else                clip = raw[LANE_W-1:0];
    end
    assign sum[g*LANE_W +: LANE_W] = clip;

    // R7: adding a non-negative value never lowers a lane, a negative one never raises it
    always_comb begin
      if (!sb[LANE_W-1]) begin
        assert_sat_no_wrap_up_R7: assert (clip >= ua);
      end else begin
        assert_sat_no_wrap_down_R7: assert (clip <= ua);
      end
    end
  end
endmodule

// File: rtl/media_simd_unit.sv
module media_simd_unit
  import media_simd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  op_sel,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic        res_valid,
  output logic [31:0] res_data
);
  logic [DATA_W-1:0] dot8_ss, dot8_su, dot16, sad8, addsat8;
  logic [DATA_W-1:0] res_next;
  logic              data_en;

  simd_lane_dot #(.DATA_W(DATA_W), .LANE_W(8)) u_dot8_ss (
    .a_signed(1'b1), .b_signed(1'b1), .opa(src_a), .opb(src_b), .dot(dot8_ss)
  );
  simd_lane_dot #(.DATA_W(DATA_W), .LANE_W(8)) u_dot8_su (
    .a_signed(1'b1), .b_signed(1'b0), .opa(src_a), .opb(src_b), .dot(dot8_su)
  );
  simd_lane_dot #(.DATA_W(DATA_W), .LANE_W(16)) u_dot16 (
    .a_signed(1'b1), .b_signed(1'b1), .opa(src_a), .opb(src_b), .dot(dot16)
  );
  simd_lane_sad #(.DATA_W(DATA_W), .LANE_W(8)) u_sad8 (
    .opa(src_a), .opb(src_b), .sad(sad8)
  );
  simd_lane_addsat #(.DATA_W(DATA_W), .LANE_W(8)) u_addsat8 (
    .opa(src_a), .opb(src_b), .sum(addsat8)
  );

  always_comb begin
    unique case (op_sel)
      OP_DOT8_SS: res_next = dot8_ss;
      OP_DOT8_SU: res_next = dot8_su;
      OP_DOT16:   res_next = dot16;
      OP_SAD8:    res_next = sad8;
      OP_ADDSAT8: res_next = addsat8;
      default:    res_next = '0;
    endcase
  end

  assign data_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (data_en) res_data <= res_next;
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));
  assert_sad_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd3) |=> (res_data <= 32'd1020));
  assert_undef_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 3'd4) |=> (res_data == 32'd0));
endmodule

// File: tb/test_media_simd_unit.sv
module test_media_simd_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op_sel;
  logic [31:0] src_a, src_b;
  logic        res_valid;
  logic [31:0] res_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  media_simd_unit i_media_simd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_dot8(input logic [31:0] a, input logic [31:0] b, input bit b_sgn);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int x, y;
      x = int'($signed(a[8*i +: 8]));
      y = b_sgn ? int'($signed(b[8*i +: 8])) : int'(b[8*i +: 8]);
      s += x * y;
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_dot16(input logic [31:0] a, input logic [31:0] b);
    int s;
    s = int'($signed(a[15:0])) * int'($signed(b[15:0]))
      + int'($signed(a[31:16])) * int'($signed(b[31:16]));
    return s;
  endfunction

  function automatic logic [31:0] ref_sad(input logic [31:0] a, input logic [31:0] b);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
      s += (d < 0) ? -d : d;
    end
    return s;
  endfunction

  function automatic logic [31:0] ref_sat(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      int v;
      v = int'(a[8*i +: 8]) + int'($signed(b[8*i +: 8]));
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      r[8*i +: 8] = v[7:0];
    end
    return r;
  endfunction

  // issue one operation, check the result and valid one clock later
  task automatic issue(input string req, input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, res_valid}, 32'd1);
    check(req, res_data, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 3'd0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {31'd0, res_valid}, 32'd0);
    check("R1 data in reset", res_data, 32'd0);
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 valid held low in reset", {31'd0, res_valid}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {31'd0, res_valid}, 32'd0);
  endtask

  task automatic t_dot_ss;
    issue("R3 all 0x80", 3'd0, 32'h80808080, 32'h80808080, 32'd65536);
    issue("R3 all 0xFF", 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd4);
    issue("R3 mixed", 3'd0, 32'h7F80FF03, 32'h02FE7F81, ref_dot8(32'h7F80FF03, 32'h02FE7F81, 1'b1));
  endtask

  task automatic t_dot_su;
    issue("R4 all 0xFF", 3'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFC04);
    issue("R4 0x80 x 0xFF", 3'd1, 32'h80808080, 32'hFFFFFFFF, ref_dot8(32'h80808080, 32'hFFFFFFFF, 1'b0));
    issue("R4 mixed", 3'd1, 32'h7F80FF03, 32'h02FE7F81, ref_dot8(32'h7F80FF03, 32'h02FE7F81, 1'b0));
  endtask

  task automatic t_dot16;
    issue("R5 wrap point", 3'd2, 32'h80008000, 32'h80008000, 32'h80000000);
    issue("R5 mixed sign", 3'd2, 32'hFFFE1234, 32'h7FFF8001, ref_dot16(32'hFFFE1234, 32'h7FFF8001));
  endtask

  task automatic t_sad;
    issue("R6 mixed order", 3'd3, 32'h10F00520, 32'hF0100A20, ref_sad(32'h10F00520, 32'hF0100A20));
    issue("R6 maximum", 3'd3, 32'h00FF00FF, 32'hFF00FF00, 32'd1020);
    issue("R6 equal", 3'd3, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'd0);
  endtask

  task automatic t_sat;
    // lane3 overflow, lane2 underflow, lane1 in range, lane0 negative in range
    issue("R7 mixed clamps", 3'd4, 32'hF0103050, 32'h20E00AF6, 32'hFF003A46);
    issue("R7 model", 3'd4, 32'h807F01FE, 32'h7F807F80, ref_sat(32'h807F01FE, 32'h7F807F80));
  endtask

  task automatic t_undef;
    for (int c = 5; c < 8; c++) begin
      issue("R8 undefined code", 3'(c), 32'h12345678, 32'h9ABCDEF0, 32'd0);
    end
  endtask

  task automatic t_idle_hold;
    logic [31:0] kept;
    issue("R2 latency", 3'd3, 32'h00000009, 32'h00000002, 32'd7);
    kept = res_data;
    op_sel = 3'd4; src_a = 32'hFFFFFFFF; src_b = 32'h7F7F7F7F;
    repeat (3) begin
      @(negedge clk);
      check("R2 valid low when idle", {31'd0, res_valid}, 32'd0);
      check("R9 data held when idle", res_data, kept);
    end
  endtask

  initial begin
    t_reset();
    t_dot_ss();
    t_dot_su();
    t_dot16();
    t_sad();
    t_sat();
    t_undef();
    t_idle_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule